// File: doc/BRIEF.md
# Dual-Half NAND Page Hamming Code Generator

This block watches the byte stream on a NAND data path and builds a single-error-correcting Hamming code for a 512-byte page. The page is coded as two independent 256-byte halves, and each half gets 16 line-parity bits and 6 column-parity bits. Software later compares the code read from the spare area with the code computed here, and it can then repair one flipped bit in each half.

The block is driven by byte-wide mode commands:

- One command clears the accumulators.
- One command arms accumulation.
- One command switches the data port to result readout.
- The plain data-mode command returns the port to normal data traffic.

In result readout the six code bytes come out as three 16-bit words in a fixed interleaved order. Each word is advanced by a read of the port.

Top module: `nand_ecc_pair`

## Requirements
- R1: After reset the block is disarmed and not in readout, and `rd_word` is 0. Both halves hold an all-zero code, so an immediate readout yields 0x0000, 0x0003, 0x0300.
- R2: A mode write of 0xF4 clears both halves' parity, the byte address and the half selector, and leaves the block disarmed. A readout that follows yields 0x0000, 0x0003, 0x0300.
- R3: A mode write of 0xB4 arms the block. While it is armed, every cycle with `byte_vld` high folds `byte_val` into the current half's code.
- R4: A byte presented while the block is not armed does not change the code. This covers the dummy read after 0xF4, bytes seen during readout, and bytes seen after 0x94.
- R5: For each byte at address a (0..255) within its half, p is the XOR of the byte's bits. For each address bit i, p toggles LP[2i+1] when a[i] is 1, and toggles LP[2i] when a[i] is 0.
- R6: The column-parity byte of a half carries CP5..CP0 in bits 7:2, with bits 1:0 forced to 1. X is the XOR of all bytes of the half. The CP bits are parities of X as follows:
  - CP0 covers bits {0,2,4,6} and CP1 covers bits {1,3,5,7}.
  - CP2 covers bits {0,1,4,5} and CP3 covers bits {2,3,6,7}.
  - CP4 covers bits {0..3} and CP5 covers bits {4..7}.
- R7: Folded bytes 0..255 go to the first half and bytes 256..511 go to the second half. Once 512 bytes have been folded, further bytes are ignored until the next 0xF4.
- R8: A mode write of 0xD4 disarms the block and enters readout at the first word. The three words are:
  - word 1 = {LP7..0 of half 0, LP15..8 of half 0}
  - word 2 = {LP7..0 of half 1, CP byte of half 0}
  - word 3 = {CP byte of half 1, LP15..8 of half 1}
  Each word is written {bits 15:8, bits 7:0}.
- R9: In readout, `rd_word` shows the current word. Each `port_rd` advances to the next word, and the read after word 3 returns word 1 again.
- R10: Any mode write other than 0xD4 leaves readout. Any mode write other than 0xB4 disarms the block. Outside readout, `rd_word` is 0.
- R11: A readout requested before 512 bytes have been folded returns the partial code of the bytes folded so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode command strobe |
| mode_val | input | 8 | Mode command code |
| byte_vld | input | 1 | A data byte is transferred this cycle |
| byte_val | input | 8 | Transferred data byte |
| port_rd | input | 1 | Data-port read strobe, advances readout |
| rd_word | output | 16 | Result word in readout, else 0 |
| result_sel | output | 1 | Readout mode is active |

## Verification
The assertions assume that mode writes are single-cycle strobes and that `byte_vld` and `port_rd` are meaningful only as one-cycle pulses. They make no assumption about which codes appear on `mode_val`, so the hold and freeze properties must survive stray bytes in every mode. The stimulus drives every input at the falling edge, issues at most one kind of event per cycle, and samples `rd_word` at the falling edge after the command has taken effect. It deliberately sends bytes while the block is disarmed, during readout, and past the 512-byte limit, so the hold properties are exercised rather than vacuous.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int HALF_AW = 8;             // byte address bits per half
  localparam int LP_W    = 2 * HALF_AW;   // line parity bits per half
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int HALVES  = 2;

  localparam logic [BYTE_W-1:0] MODE_CLEAR  = 8'hF4;
  localparam logic [BYTE_W-1:0] MODE_CALC   = 8'hB4;
  localparam logic [BYTE_W-1:0] MODE_RESULT = 8'hD4;
  localparam logic [BYTE_W-1:0] MODE_DATA   = 8'h94;

  // toggle one line parity bit per address bit, chosen by that bit's value
  function automatic logic [LP_W-1:0] lp_fold(input logic [LP_W-1:0] lp,
                                              input logic [HALF_AW-1:0] addr,
                                              input logic par);
    logic [LP_W-1:0] r;
    r = lp;
    for (int i = 0; i < HALF_AW; i++) begin
      if (addr[i]) r[2*i+1] = r[2*i+1] ^ par;
      else         r[2*i]   = r[2*i]   ^ par;
    end
    return r;
  endfunction

  // column parity byte from the XOR of all bytes of a half
  function automatic logic [BYTE_W-1:0] cp_byte(input logic [BYTE_W-1:0] cx);
    return {^(cx & 8'hF0), ^(cx & 8'h0F), ^(cx & 8'hCC),
            ^(cx & 8'h33), ^(cx & 8'hAA), ^(cx & 8'h55), 2'b11};
  endfunction
endpackage

// File: rtl/ecc_mode_ctl.sv
module ecc_mode_ctl
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [BYTE_W-1:0] mode_val,
  output logic              armed,
  output logic              readout,
  output logic              clr_evt,
  output logic              enter_evt
);
  assign clr_evt   = mode_wr && (mode_val == MODE_CLEAR);
  assign enter_evt = mode_wr && (mode_val == MODE_RESULT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      readout <= 1'b0;
    end else if (mode_wr) begin
      armed   <= (mode_val == MODE_CALC);
      readout <= (mode_val == MODE_RESULT);
    end
  end
endmodule

// File: rtl/ecc_byte_seq.sv
module ecc_byte_seq
  import nand_ecc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               fold_req,
  output logic [HALF_AW-1:0] addr,
  output logic               half,
  output logic               full,
  output logic               fold_evt,
  output logic               wrap_evt
);
  assign fold_evt = fold_req && !full;
  assign wrap_evt = fold_evt && (&addr);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      addr <= '0;
      half <= 1'b0;
      full <= 1'b0;
    end else if (fold_evt) begin
      addr <= addr + 1'b1;
      if (wrap_evt) begin
        if (half) full <= 1'b1;
        else      half <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecc_half_acc.sv
module ecc_half_acc
  import nand_ecc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               en,
  input  logic [HALF_AW-1:0] addr,
  input  logic [BYTE_W-1:0]  data,
  output logic [LP_W-1:0]    lp,
  output logic [BYTE_W-1:0]  cx
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lp <= '0;
      cx <= '0;
    end else if (en) begin
      lp <= lp_fold(lp, addr, ^data);
      cx <= cx ^ data;
    end
  end
endmodule

// File: rtl/ecc_readout.sv
module ecc_readout
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enter,
  input  logic              active,
  input  logic              port_rd,
  input  logic [LP_W-1:0]   lp0,
  input  logic [BYTE_W-1:0] cx0,
  input  logic [LP_W-1:0]   lp1,
  input  logic [BYTE_W-1:0] cx1,
  output logic [1:0]        idx,
  output logic [WORD_W-1:0] word
);
  logic [BYTE_W-1:0] cpb0, cpb1;
  assign cpb0 = cp_byte(cx0);
  assign cpb1 = cp_byte(cx1);

  always_ff @(posedge clk) begin
    if (!rst_n || enter)        idx <= 2'd0;
    else if (active && port_rd) idx <= (idx == 2'd2) ? 2'd0 : idx + 2'd1;
  end

  always_comb begin
    word = '0;
    if (active) begin
      case (idx)
        2'd0:    word = {lp0[7:0], lp0[15:8]};
        2'd1:    word = {lp1[7:0], cpb0};
        default: word = {cpb1, lp1[15:8]};
      endcase
    end
  end
endmodule

// File: rtl/nand_ecc_pair.sv
module nand_ecc_pair
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [7:0]        mode_val,
  input  logic              byte_vld,
  input  logic [7:0]        byte_val,
  input  logic              port_rd,
  output logic [15:0]       rd_word,
  output logic              result_sel
);
  logic               armed, clr_evt, enter_evt;
  logic [HALF_AW-1:0] addr;
  logic               half, full, fold_evt, wrap_evt;
  logic [1:0]         rd_idx;
  logic [LP_W-1:0]    lp_h [HALVES];
  logic [BYTE_W-1:0]  cx_h [HALVES];

  ecc_mode_ctl mode_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
    .armed(armed), .readout(result_sel), .clr_evt(clr_evt), .enter_evt(enter_evt)
  );

  ecc_byte_seq seq_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_evt), .fold_req(armed && byte_vld),
    .addr(addr), .half(half), .full(full), .fold_evt(fold_evt), .wrap_evt(wrap_evt)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    ecc_half_acc acc_i (
      .clk(clk), .rst_n(rst_n), .clr(clr_evt),
      .en(fold_evt && (half == 1'(h))),
      .addr(addr), .data(byte_val), .lp(lp_h[h]), .cx(cx_h[h])
    );
  end

  ecc_readout rd_i (
    .clk(clk), .rst_n(rst_n), .enter(enter_evt), .active(result_sel),
    .port_rd(port_rd), .lp0(lp_h[0]), .cx0(cx_h[0]), .lp1(lp_h[1]), .cx1(cx_h[1]),
    .idx(rd_idx), .word(rd_word)
  );
endmodule

// File: rtl/nand_ecc_pair_chk.sv
module nand_ecc_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_wr,
  input logic [7:0]  mode_val,
  input logic        byte_vld,
  input logic [15:0] rd_word,
  input logic        result_sel,
  input logic        armed,
  input logic        wrap_evt,
  input logic        half,
  input logic        full,
  input logic [1:0]  rd_idx,
  input logic [15:0] lp0,
  input logic [15:0] lp1,
  input logic [7:0]  cx0,
  input logic [7:0]  cx1
);
  logic clr_cmd;
  assign clr_cmd = mode_wr && (mode_val == 8'hF4);

  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (lp0 == 16'h0) && (lp1 == 16'h0) && (cx0 == 8'h0) && (cx1 == 8'h0) && !half && !full);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && byte_vld) && !clr_cmd |=> $stable(lp0) && $stable(lp1) && $stable(cx0) && $stable(cx1));

  a_r7_switch: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt && !half |=> half && !full);

  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    full && !clr_cmd |=> $stable(lp0) && $stable(lp1) && $stable(cx0) && $stable(cx1));

  a_r8_enter: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && (mode_val == 8'hD4) |=> result_sel && (rd_idx == 2'd0) && !armed);

  a_r9_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx != 2'd3);

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !result_sel |-> rd_word == 16'h0);

  a_r10_leave: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && (mode_val != 8'hD4) |=> !result_sel);
endmodule

bind nand_ecc_pair nand_ecc_pair_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
  .byte_vld(byte_vld), .rd_word(rd_word), .result_sel(result_sel),
  .armed(armed), .wrap_evt(wrap_evt), .half(half), .full(full),
  .rd_idx(rd_idx), .lp0(lp_h[0]), .lp1(lp_h[1]), .cx0(cx_h[0]), .cx1(cx_h[1])
);

// File: tb/nand_ecc_pair_tb.sv
module nand_ecc_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [7:0]  mode_val = 8'h0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_val = 8'h0;
  logic        port_rd = 1'b0;
  logic [15:0] rd_word;
  logic        result_sel;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nand_ecc_pair dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_val(mode_val),
    .byte_vld(byte_vld), .byte_val(byte_val), .port_rd(port_rd),
    .rd_word(rd_word), .result_sel(result_sel)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic [9:0]  seed;
    logic [10:0] len;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 10'd0,   11'd512},
    '{3'd1, 10'd0,   11'd512},
    '{3'd2, 10'h5A,  11'd512},
    '{3'd3, 10'd3,   11'd512},
    '{3'd4, 10'd300, 11'd512},
    '{3'd3, 10'd9,   11'd300},
    '{3'd2, 10'd1,   11'd600},
    '{3'd1, 10'd0,   11'd256}
  };

  logic [7:0]  mem [512];
  logic [15:0] exp_w [3];

  function automatic logic [7:0] pat(input logic [2:0] kind, input int seed, input int i);
    int t;
    case (kind)
      3'd0:    return 8'h00;
      3'd1:    return 8'hFF;
      3'd2:    return 8'(i) ^ 8'(seed);
      3'd3:    begin t = (i * 37 + seed * 11) ^ (i >> 3); return 8'(t); end
      default: return (i == seed) ? (8'h01 << (seed % 8)) : 8'h00;
    endcase
  endfunction

  // code of the first n bytes of mem, computed bit by bit
  task automatic model(input int n);
    logic [15:0] lp [2];
    logic [7:0]  cpb [2];
    logic [7:0]  x;
    for (int h = 0; h < 2; h++) begin
      lp[h] = '0;
      x = '0;
      for (int j = h * 256; j < n && j < (h + 1) * 256; j++) begin
        for (int k = 0; k < 16; k++)
          if ((((j % 256) >> (k / 2)) & 1) == (k % 2)) lp[h][k] ^= ^mem[j];
        x ^= mem[j];
      end
      cpb[h] = 8'h03;
      for (int c = 0; c < 6; c++)
        for (int b = 0; b < 8; b++)
          if (((b >> (c / 2)) & 1) == (c % 2)) cpb[h][c + 2] ^= x[b];
    end
    exp_w[0] = {lp[0][7:0], lp[0][15:8]};
    exp_w[1] = {lp[1][7:0], cpb[0]};
    exp_w[2] = {cpb[1], lp[1][15:8]};
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic [7:0] v);
    mode_wr = 1'b1; mode_val = v;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    byte_vld = 1'b1; byte_val = b;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic rd(output logic [15:0] w);
    w = rd_word;
    port_rd = 1'b1;
    @(negedge clk);
    port_rd = 1'b0;
  endtask

  task automatic read_check(input string tag);
    logic [15:0] w;
    for (int k = 0; k < 3; k++) begin
      rd(w);
      chk(tag, w, exp_w[k]);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rd_word after reset", rd_word, 16'h0);
    chk("R1 result_sel after reset", {15'h0, result_sel}, 16'h0);
    set_mode(8'hD4);
    chk("R8 result_sel on 0xD4", {15'h0, result_sel}, 16'h1);
    model(0);
    read_check("R1 zero code");
    rd(w);
    chk("R9 wrap to word 1", w, exp_w[0]);

    // table-driven pages: R3 R5 R6 R7 R8 R11
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < 512; i++) mem[i] = pat(VECS[v].kind, int'(VECS[v].seed), i);
      set_mode(8'hF4);
      push(8'hFF);                // dummy read while disarmed, R4
      set_mode(8'hB4);
      for (int i = 0; i < int'(VECS[v].len); i++) begin
        byte_vld = 1'b1;
        byte_val = pat(VECS[v].kind, int'(VECS[v].seed), i);
        @(negedge clk);
      end
      byte_vld = 1'b0;
      set_mode(8'hD4);
      model((int'(VECS[v].len) > 512) ? 512 : int'(VECS[v].len));
      read_check($sformatf("R3 R5 R6 R7 R11 vector %0d", v));
      set_mode(8'h94);
      chk("R10 rd_word after 0x94", rd_word, 16'h0);
      chk("R10 result_sel after 0x94", {15'h0, result_sel}, 16'h0);
    end

    // R4: bytes outside armed mode are ignored
    for (int i = 0; i < 10; i++) mem[i] = pat(3'd3, 1, i);
    set_mode(8'hF4);
    set_mode(8'hB4);
    for (int i = 0; i < 10; i++) push(mem[i]);
    set_mode(8'hD4);
    model(10);
    read_check("R11 partial 10 bytes");
    for (int i = 0; i < 5; i++) push(8'hA5);
    set_mode(8'hD4);
    read_check("R4 bytes during readout ignored");
    set_mode(8'h94);
    for (int i = 0; i < 5; i++) push(8'h3C);
    set_mode(8'hD4);
    read_check("R4 bytes after 0x94 ignored");

    // R2: clear empties the code
    set_mode(8'hF4);
    set_mode(8'hD4);
    model(0);
    read_check("R2 code after 0xF4");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule